// File: doc/BRIEF.md
# DMA Transfer Timeout Control/Status Register

This block is the control and status register of one DMA channel, together with a watchdog that notices when a transfer has stalled. Software programs an enable bit and a 5-bit timeout value in milliseconds. Hardware reports two sticky conditions in the same register: a timeout and a partial packet. Software clears each of these by writing a one to its bit.

The watchdog is driven by the once-per-millisecond start-of-frame tick, not by the clock. It arms on the first byte the channel moves, provided the timeout enable and the channel enable are both on. Every further byte reloads the count from the programmed value. Each tick takes one off the count. When the count is found at zero, the timeout flag is raised and a single-cycle halt request goes to the DMA engine.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `dma_tmo_csr`

## Requirements
- R1: After reset, every register bit reads 0 and `halt_pulse` is low.
- R2: The register layout is as follows. Bit 7 is the timeout enable. Bits 6:2 are the timeout value in 1 ms units, where 0 means 0 ms and 31 means 31 ms. Bit 1 is the timeout flag. Bit 0 is the partial-packet flag. A write loads bits 7:2 and reads them back unchanged, and a write never sets bits 1:0.
- R3: Writing 1 to bit 1 or bit 0 clears that flag. Writing 0 leaves it unchanged.
- R4: When hardware sets a flag in the same cycle that software writes 1 to it, the flag ends up set.
- R5: A `pkt_partial` pulse sets bit 0. The bit stays set until software clears it.
- R6: The watchdog arms only on a `byte_xfer` strobe that arrives while both the timeout enable and `chan_en` are 1. Before that, SOF ticks have no effect.
- R7: Every `byte_xfer` strobe reloads the count from bits 6:2. A byte strobe in the same cycle as an SOF tick reloads, and the tick is not counted.
- R8: While armed, each SOF tick decrements the count. In the cycle after the count is zero, the timeout flag sets. With a value of N, this is one cycle after the Nth tick since the last byte. With a value of 0, it is one cycle after the arming byte. The timeout disarms the watchdog.
- R9: `halt_pulse` is high for exactly one cycle, and that is the cycle in which the timeout flag first reads 1.
- R10: When the timeout enable is 0, the watchdog never times out. When `chan_en` drops, the watchdog disarms, and a fresh byte is needed to arm it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| chan_en | input | 1 | Channel enable from the DMA descriptor |
| byte_xfer | input | 1 | One-cycle strobe, one byte moved in either direction |
| pkt_partial | input | 1 | One-cycle strobe, partial packet detected |
| sof_tick | input | 1 | One-cycle start-of-frame tick, every 1 ms |
| halt_pulse | output | 1 | One-cycle request to halt the DMA transfer |

## Verification
The bench programs value 3 and lets the watchdog run out. It also interleaves bytes with ticks, including a byte and a tick in the same cycle. A design that decremented on that cycle, or that counted from a stale value, would time out one tick early.

Further cases cover:
- dropping the channel enable mid-count, then sending ticks with no new byte, where a design that stayed armed would raise a spurious timeout;
- a disabled watchdog, which must never fire;
- the 0 ms value, which must fire one cycle after the arming byte;
- a write that clears a flag in the same cycle hardware sets it, where a design that let the clear win would lose the event;
- writes of 0 and of all ones to the flag bits, where a design that lets writes set or clear the flags wrongly would show it.

// File: rtl/dma_tmo_pkg.sv
package dma_tmo_pkg;
  localparam int TMO_CNT_W = 5;
  localparam int FLAG_PP   = 0;
  localparam int FLAG_TMO  = 1;
  localparam int NUM_FLAGS = 2;
  localparam int VAL_LSB   = NUM_FLAGS;

  typedef enum logic [0:0] {
    WDOG_IDLE  = 1'b0,
    WDOG_ARMED = 1'b1
  } wdog_state_e;
endpackage

// File: rtl/tmo_cfg_reg.sv
module tmo_cfg_reg #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             ten_wr_i,
  input  logic [CNT_W-1:0] tval_wr_i,
  output logic             ten_o,
  output logic [CNT_W-1:0] tval_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ten_o  <= 1'b0;
      tval_o <= '0;
    end else if (wr_i) begin
      ten_o  <= ten_wr_i;
      tval_o <= tval_wr_i;
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(ten_o) && $stable(tval_o)));
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/tmo_watchdog.sv
module tmo_watchdog
  import dma_tmo_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ten_i,
  input  logic [CNT_W-1:0] tval_i,
  input  logic             chan_en_i,
  input  logic             byte_xfer_i,
  input  logic             sof_tick_i,
  output logic             fire_o,
  output logic             halt_o
);
  wdog_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             live;
  logic             armed;

  assign live   = ten_i & chan_en_i;
  assign armed  = (state_q == WDOG_ARMED);
  assign fire_o = armed & live & ~byte_xfer_i & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WDOG_IDLE;
      cnt_q   <= '0;
      halt_o  <= 1'b0;
    end else begin
      halt_o <= fire_o;
      if (!live || fire_o)  state_q <= WDOG_IDLE;
      else if (byte_xfer_i) state_q <= WDOG_ARMED;
      if (byte_xfer_i)
        cnt_q <= tval_i;
      else if (armed && live && sof_tick_i && (cnt_q != '0))
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_i |=> (state_q == WDOG_IDLE));
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_xfer_i |=> (cnt_q == $past(tval_i)));
  // R9
  halt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> !halt_o);
  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (state_q == WDOG_IDLE));
endmodule

// File: rtl/dma_tmo_csr.sv
module dma_tmo_csr
  import dma_tmo_pkg::*;
#(
  parameter int CNT_W = TMO_CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [CNT_W+VAL_LSB:0] reg_wdata,
  output logic [CNT_W+VAL_LSB:0] reg_rdata,
  input  logic                   chan_en,
  input  logic                   byte_xfer,
  input  logic                   pkt_partial,
  input  logic                   sof_tick,
  output logic                   halt_pulse
);
  localparam int VAL_MSB = VAL_LSB + CNT_W - 1;
  localparam int TEN_BIT = VAL_MSB + 1;

  logic             ten;
  logic [CNT_W-1:0] tval;
  logic             fire;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;

  tmo_cfg_reg #(.CNT_W(CNT_W)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .ten_wr_i  (reg_wdata[TEN_BIT]),
    .tval_wr_i (reg_wdata[VAL_MSB:VAL_LSB]),
    .ten_o     (ten),
    .tval_o    (tval)
  );

  tmo_watchdog #(.CNT_W(CNT_W)) i_wdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .ten_i       (ten),
    .tval_i      (tval),
    .chan_en_i   (chan_en),
    .byte_xfer_i (byte_xfer),
    .sof_tick_i  (sof_tick),
    .fire_o      (fire),
    .halt_o      (halt_pulse)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_PP]  = pkt_partial;
    flag_set[FLAG_TMO] = fire;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sticky_flag i_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[g]),
      .clr_i (reg_wr & reg_wdata[g]),
      .q_o   (flag_q[g])
    );
  end

  assign reg_rdata = {ten, tval, flag_q};

  // R9
  halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> (reg_rdata[FLAG_TMO] && !$past(reg_rdata[FLAG_TMO])));
  // R5
  pp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_partial |=> reg_rdata[FLAG_PP]);
endmodule

// File: tb/test_dma_tmo_csr.sv
module test_dma_tmo_csr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       chan_en = 1'b0;
  logic       byte_xfer = 1'b0;
  logic       pkt_partial = 1'b0;
  logic       sof_tick = 1'b0;
  logic       halt_pulse;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_tmo_csr i_dma_tmo_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chan_en(chan_en), .byte_xfer(byte_xfer),
    .pkt_partial(pkt_partial), .sof_tick(sof_tick), .halt_pulse(halt_pulse)
  );

  // {req, wr, wdata, en, byte, pp, sof, exp_rdata, exp_halt}
  function automatic logic [25:0] v(int rq, bit w, logic [7:0] d, bit e, bit b,
                                    bit p, bit s, logic [7:0] r, bit h);
    return {rq[3:0], w, d, e, b, p, s, r, h};
  endfunction

  localparam int NV = 46;
  localparam logic [25:0] VEC [NV] = '{
    v(2, 1,8'h8C,1,0,0,0, 8'h8C,0), // R2 ten=1 value=3
    v(6, 0,8'h00,1,1,0,0, 8'h8C,0), // R6 arm
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8 count 2
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8 count 1
    v(7, 0,8'h00,1,1,0,0, 8'h8C,0), // R7 reload 3
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8 count 0
    v(9, 0,8'h00,1,0,0,0, 8'h8E,1), // R9 fire
    v(9, 0,8'h00,1,0,0,0, 8'h8E,0), // R9 single cycle
    v(3, 1,8'h8C,1,0,0,0, 8'h8E,0), // R3 write 0 no effect
    v(3, 1,8'h8E,1,0,0,0, 8'h8C,0), // R3 write 1 clears
    v(5, 0,8'h00,1,0,1,0, 8'h8D,0), // R5 partial set
    v(4, 1,8'h8D,1,0,1,0, 8'h8D,0), // R4 set wins
    v(3, 1,8'h8D,1,0,0,0, 8'h8C,0), // R3 clear pp
    v(6, 0,8'h00,1,1,0,0, 8'h8C,0), // R6 arm
    v(10,0,8'h00,0,0,0,1, 8'h8C,0), // R10 chan_en drop
    v(10,0,8'h00,1,0,0,1, 8'h8C,0), // R10
    v(10,0,8'h00,1,0,0,1, 8'h8C,0), // R10
    v(10,0,8'h00,1,0,0,1, 8'h8C,0), // R10
    v(10,0,8'h00,1,0,0,1, 8'h8C,0), // R10
    v(10,0,8'h00,1,0,0,0, 8'h8C,0), // R10 no spurious fire
    v(6, 0,8'h00,1,1,0,0, 8'h8C,0), // R6 rearm
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8
    v(8, 0,8'h00,1,0,0,1, 8'h8C,0), // R8
    v(8, 0,8'h00,1,0,0,0, 8'h8E,1), // R8 fire after rearm
    v(10,1,8'h0E,1,0,0,0, 8'h0C,0), // R10 ten off, clear flag
    v(10,0,8'h00,1,1,0,0, 8'h0C,0), // R10
    v(10,0,8'h00,1,0,0,1, 8'h0C,0), // R10
    v(10,0,8'h00,1,0,0,1, 8'h0C,0), // R10
    v(10,0,8'h00,1,0,0,1, 8'h0C,0), // R10
    v(10,0,8'h00,1,0,0,0, 8'h0C,0), // R10
    v(10,0,8'h00,1,0,0,0, 8'h0C,0), // R10 never fires
    v(2, 1,8'h80,1,0,0,0, 8'h80,0), // R2 value 0
    v(8, 0,8'h00,1,1,0,0, 8'h80,0), // R8 arm at 0
    v(8, 0,8'h00,1,0,0,0, 8'h82,1), // R8 0 ms fire
    v(9, 0,8'h00,1,0,0,0, 8'h82,0), // R9
    v(3, 1,8'h8A,1,0,0,0, 8'h88,0), // R3 value 2, clear
    v(6, 0,8'h00,1,1,0,0, 8'h88,0), // R6
    v(8, 0,8'h00,1,0,0,1, 8'h88,0), // R8 count 1
    v(7, 0,8'h00,1,1,0,1, 8'h88,0), // R7 byte beats tick
    v(8, 0,8'h00,1,0,0,1, 8'h88,0), // R8 count 1
    v(7, 0,8'h00,1,0,0,0, 8'h88,0), // R7 no early fire
    v(8, 0,8'h00,1,0,0,1, 8'h88,0), // R8 count 0
    v(9, 0,8'h00,1,0,0,0, 8'h8A,1)  // R9 fire
  };

  task automatic check(int rq, logic [7:0] er, bit eh);
    n_vec++;
    if (reg_rdata !== er || halt_pulse !== eh) begin
      n_bad++;
      $display("FAIL R%0d: rdata=%h halt=%b expected rdata=%h halt=%b",
               rq, reg_rdata, halt_pulse, er, eh);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = '0; byte_xfer = 0; pkt_partial = 0; sof_tick = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, 8'h00, 1'b0); // R1 reset state
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr = VEC[i][21]; reg_wdata = VEC[i][20:13]; chan_en = VEC[i][12];
      byte_xfer = VEC[i][11]; pkt_partial = VEC[i][10]; sof_tick = VEC[i][9];
      @(posedge clk);
      #1 check(int'(VEC[i][25:22]), VEC[i][8:1], VEC[i][0]);
    end
    // R1 reset in the middle of activity
    @(negedge clk) idle(); pkt_partial = 1;
    @(negedge clk) idle(); rst_n = 0;
    @(posedge clk); #1 check(1, 8'h00, 1'b0);
    // R2 write all ones: fields load, flags stay clear
    @(negedge clk) rst_n = 1; reg_wr = 1; reg_wdata = 8'hFF;
    @(posedge clk); #1 check(2, 8'hFC, 1'b0);
    // R6 byte with channel disabled does not arm
    @(negedge clk) idle(); reg_wr = 1; reg_wdata = 8'h80; chan_en = 0;
    @(negedge clk) idle(); byte_xfer = 1;
    @(negedge clk) idle(); chan_en = 1;
    @(negedge clk);
    @(posedge clk); #1 check(6, 8'h80, 1'b0);
    @(negedge clk) idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule